// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block decides, frame by frame, whether an incoming Ethernet frame is kept or thrown away. It watches a receive byte stream that carries byte-valid, start-of-frame and end-of-frame strobes. It compares the destination address field against a programmed 48-bit station address. It also acts on a frame-check result flag that the upstream CRC checker supplies together with the last byte.

The block has three mode controls. The first enables bad-CRC rejection. The second enables promiscuous reception. The third makes the block accept multicast destinations as well. One clock after the last byte of a frame, the block gives a single-cycle keep or discard verdict. When a frame is rejected for a CRC failure, it also raises a receive-error pulse. The station address and the mode controls are captured at start of frame, so software can reprogram them at any time without disturbing a frame that is already in progress.

Top module: `rx_frame_filter`

## Requirements
- R1: While reset is asserted and after its release, `accept_o`, `drop_o` and `rx_err_o` are low until a frame ends.
- R2: For a byte carrying `eof_i`, exactly one of `accept_o`/`drop_o` is high for one cycle in the cycle after that byte. Both are low in every other cycle.
- R3: With promiscuous and multicast modes off, a frame of 6 or more bytes with a passing CRC is accepted only if its first 6 bytes equal the station address in wire order. A difference in any one of those bytes drops the frame.
- R4: The station address comes from two 32-bit words. Wire octets 0, 1 and 2 are `addr_lo_i[7:0]`, `[15:8]` and `[23:16]`. Wire octets 3, 4 and 5 are `addr_hi_i[7:0]`, `[15:8]` and `[23:16]`. Bits 31:24 of both words have no effect.
- R5: In promiscuous mode, a frame of 6 or more bytes that is not rejected for CRC is accepted, whatever its destination.
- R6: In multicast mode, a frame whose first byte has bit 0 set is also accepted. The broadcast address FF-FF-FF-FF-FF-FF is included. With multicast mode off, such a frame is accepted only on an exact match or in promiscuous mode.
- R7: With bad-CRC rejection on and `fcs_bad_i` high on the last byte, the frame is dropped and `rx_err_o` pulses in the same cycle as `drop_o`.
- R8: With bad-CRC rejection off, `fcs_bad_i` has no effect on the verdict, and `rx_err_o` stays low.
- R9: A frame of fewer than 6 bytes is dropped in every mode.
- R10: The mode controls and both address words are sampled with the start-of-frame byte. Changing them later in the frame does not alter that frame's verdict or error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Byte strobe; `sof_i`, `eof_i` and `fcs_bad_i` count only with it |
| sof_i | input | 1 | Current byte is the first byte of a frame |
| eof_i | input | 1 | Current byte is the last byte of a frame |
| byte_i | input | 8 | Receive data byte |
| fcs_bad_i | input | 1 | Frame check failed; valid on the last byte |
| addr_lo_i | input | 32 | Station address octets 0 to 2 in bits 23:0 |
| addr_hi_i | input | 32 | Station address octets 3 to 5 in bits 23:0 |
| crc_rej_i | input | 1 | Enable bad-CRC rejection |
| promisc_i | input | 1 | Enable promiscuous reception |
| mcast_en_i | input | 1 | Enable multicast acceptance |
| accept_o | output | 1 | Frame kept, one-cycle pulse |
| drop_o | output | 1 | Frame discarded, one-cycle pulse |
| rx_err_o | output | 1 | Receive error for a CRC failure, one-cycle pulse |

## Verification
Every result of this block is due exactly one clock after the posedge that takes the last byte of a frame. The bench drives each byte on a falling edge. It then reads `accept_o`, `drop_o` and `rx_err_o` on the falling edge that follows the edge that took the last byte. It reads them again one cycle later, when all three must be low again. The sweep covers every mode combination, several destination classes, both CRC outcomes and several frame lengths. Separate frames reprogram the controls and address words after start of frame, and the verdict is then checked at that same fixed offset.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DA_BYTES = 6;
  localparam int unsigned STA_W    = DA_BYTES * 8;

  typedef struct packed {
    logic             crc_rej;
    logic             promisc;
    logic             mcast_en;
    logic [STA_W-1:0] station;  // wire octet k at [8k+7:8k]
  } rxf_cfg_t;

  function automatic logic [STA_W-1:0] pack_station(input logic [23:0] lo,
                                                    input logic [23:0] hi);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/rxf_cfg_hold.sv
module rxf_cfg_hold
  import rxf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     take_i,
  input  rxf_cfg_t cfg_live_i,
  output rxf_cfg_t cfg_eff_o
);
  rxf_cfg_t held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= '0;
    else if (take_i) held_q <= cfg_live_i;
  end

  // first byte uses live settings; rest of frame uses captured copy
  assign cfg_eff_o = take_i ? cfg_live_i : held_q;

  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(held_q));
endmodule

// File: rtl/rxf_dst_track.sv
module rxf_dst_track #(
  parameter int unsigned DA_LEN = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic                sof_i,
  input  logic [7:0]          byte_i,
  input  logic [DA_LEN*8-1:0] station_i,
  output logic                len_ok_o,
  output logic                match_o,
  output logic                mcast_o
);
  localparam int unsigned CNT_W = $clog2(DA_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DA_LEN - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DA_LEN);

  logic [CNT_W-1:0] cnt_q, idx;
  logic             match_q, mcast_q;
  logic             in_da, eq;
  logic [7:0]       sel_byte;

  assign idx   = sof_i ? '0 : cnt_q;
  assign in_da = idx < FULL;

  always_comb begin
    sel_byte = '0;
    for (int k = 0; k < DA_LEN; k++)
      if (idx == CNT_W'(k)) sel_byte = station_i[8*k +: 8];
  end

  assign eq       = (byte_i == sel_byte);
  assign match_o  = (sof_i | match_q) & (~in_da | eq);
  assign mcast_o  = sof_i ? byte_i[0] : mcast_q;
  assign len_ok_o = idx >= LAST_IDX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
      mcast_q <= 1'b0;
    end else if (vld_i) begin
      cnt_q   <= in_da ? idx + 1'b1 : idx;
      match_q <= match_o;
      mcast_q <= mcast_o;
    end
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R9
  first_byte_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sof_i) |-> !len_ok_o || DA_LEN <= 1);
endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic len_ok_i,
  input  logic match_i,
  input  logic mcast_hit_i,
  input  logic fcs_bad_i,
  input  logic crc_rej_i,
  input  logic promisc_i,
  input  logic mcast_en_i,
  output logic accept_o,
  output logic drop_o,
  output logic rx_err_o
);
  logic crc_fail, addr_ok, keep;

  assign crc_fail = crc_rej_i & fcs_bad_i;
  assign addr_ok  = promisc_i | match_i | (mcast_en_i & mcast_hit_i);
  assign keep     = len_ok_i & addr_ok & ~crc_fail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      drop_o   <= 1'b0;
      rx_err_o <= 1'b0;
    end else begin
      accept_o <= done_i & keep;
      drop_o   <= done_i & ~keep;
      rx_err_o <= done_i & crc_fail;
    end
  end

  // R2
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && drop_o));
  // R2
  eof_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (accept_o || drop_o));
  // R2
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || drop_o || rx_err_o) |-> $past(done_i));
  // R7
  err_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |-> drop_o);
  // R7
  crc_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && crc_rej_i && fcs_bad_i) |=> (drop_o && rx_err_o));
  // R9
  short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !len_ok_i) |=> drop_o);
  // R5
  promisc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && len_ok_i && promisc_i && !(crc_rej_i && fcs_bad_i)) |=> accept_o);
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_vld_i,
  input  logic        sof_i,
  input  logic        eof_i,
  input  logic [7:0]  byte_i,
  input  logic        fcs_bad_i,
  input  logic [31:0] addr_lo_i,
  input  logic [31:0] addr_hi_i,
  input  logic        crc_rej_i,
  input  logic        promisc_i,
  input  logic        mcast_en_i,
  output logic        accept_o,
  output logic        drop_o,
  output logic        rx_err_o
);
  rxf_cfg_t cfg_live, cfg_eff;
  logic     take, done, len_ok, match, mcast_hit;
  logic     unused_hi;

  assign unused_hi = ^{addr_lo_i[31:24], addr_hi_i[31:24]};

  assign take = byte_vld_i & sof_i;
  assign done = byte_vld_i & eof_i;

  assign cfg_live.crc_rej  = crc_rej_i;
  assign cfg_live.promisc  = promisc_i;
  assign cfg_live.mcast_en = mcast_en_i;
  assign cfg_live.station  = pack_station(addr_lo_i[23:0], addr_hi_i[23:0]);

  rxf_cfg_hold u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .cfg_live_i (cfg_live),
    .cfg_eff_o  (cfg_eff)
  );

  rxf_dst_track #(.DA_LEN(DA_BYTES)) u_dst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (byte_vld_i),
    .sof_i     (sof_i),
    .byte_i    (byte_i),
    .station_i (cfg_eff.station),
    .len_ok_o  (len_ok),
    .match_o   (match),
    .mcast_o   (mcast_hit)
  );

  rxf_verdict u_vrd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .len_ok_i    (len_ok),
    .match_i     (match),
    .mcast_hit_i (mcast_hit),
    .fcs_bad_i   (fcs_bad_i),
    .crc_rej_i   (cfg_eff.crc_rej),
    .promisc_i   (cfg_eff.promisc),
    .mcast_en_i  (cfg_eff.mcast_en),
    .accept_o    (accept_o),
    .drop_o      (drop_o),
    .rx_err_o    (rx_err_o)
  );
endmodule

// File: tb/rx_frame_filter_test.sv
module rx_frame_filter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_vld = 1'b0, sof = 1'b0, eof = 1'b0, fcs_bad = 1'b0;
  logic [7:0]  byte_d = '0;
  logic [31:0] addr_lo = '0, addr_hi = '0;
  logic        crc_rej = 1'b0, promisc = 1'b0, mcast_en = 1'b0;
  logic        accept, drop, rx_err;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  logic [7:0]  dst [6];
  logic [7:0]  sta [6] = '{8'h02, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
  // mid-frame reprogramming
  bit          mid_en = 0;
  logic [31:0] alt_lo, alt_hi;
  logic [2:0]  alt_mode;

  always #10 clk = ~clk;  // 50 MHz

  rx_frame_filter uut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_vld_i(byte_vld), .sof_i(sof), .eof_i(eof),
    .byte_i(byte_d), .fcs_bad_i(fcs_bad), .addr_lo_i(addr_lo), .addr_hi_i(addr_hi),
    .crc_rej_i(crc_rej), .promisc_i(promisc), .mcast_en_i(mcast_en),
    .accept_o(accept), .drop_o(drop), .rx_err_o(rx_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s acc/drop/err act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic set_station(input logic [7:0] hi_lo, input logic [7:0] hi_hi);
    addr_lo = {hi_lo, sta[2], sta[1], sta[0]};
    addr_hi = {hi_hi, sta[5], sta[4], sta[3]};
  endtask

  task automatic send(input int len, input bit bad, input logic [2:0] exp, input string tag);
    logic [2:0] got;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      byte_vld = 1'b1;
      sof      = (i == 0);
      eof      = (i == len - 1);
      byte_d   = (i < 6) ? dst[i] : 8'(i * 17);
      fcs_bad  = (i == len - 1) ? bad : 1'b0;
      if (mid_en && i == 1) begin
        addr_lo = alt_lo; addr_hi = alt_hi;
        {crc_rej, promisc, mcast_en} = alt_mode;
      end
      if (i > 0 || len == 1) begin
        got = {accept, drop, rx_err};
        chk(got == 3'b000, "R2", got, 3'b000);
      end
    end
    @(negedge clk);
    byte_vld = 1'b0; sof = 1'b0; eof = 1'b0; fcs_bad = 1'b0;
    got = {accept, drop, rx_err};
    chk(got == exp, tag, got, exp);
    @(negedge clk);
    got = {accept, drop, rx_err};
    chk(got == 3'b000, "R2", got, 3'b000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] exp;
    string tag;
    repeat (3) @(negedge clk);
    // R1
    chk({accept, drop, rx_err} == 3'b000, "R1", {accept, drop, rx_err}, 3'b000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk({accept, drop, rx_err} == 3'b000, "R1", {accept, drop, rx_err}, 3'b000);

    // R4: upper bytes non-zero, must be ignored
    set_station(8'hA5, 8'h5A);

    for (int mode = 0; mode < 8; mode++)
      for (int cls = 0; cls < 9; cls++)
        for (int bad = 0; bad < 2; bad++)
          for (int li = 0; li < 4; li++) begin
            int  len;
            bit  len_ok, match, mc, addr_ok, cfail, keep;
            len = (li == 0) ? 1 : (li == 1) ? 5 : (li == 2) ? 6 : 9;
            {crc_rej, promisc, mcast_en} = 3'(mode);
            for (int k = 0; k < 6; k++) dst[k] = sta[k];
            // cls 1..6: flip bit 1 of one octet; 7: multicast miss; 8: broadcast
            if (cls >= 1 && cls <= 6) dst[cls-1] = dst[cls-1] ^ 8'h02;
            if (cls == 7) dst[0] = dst[0] | 8'h01;
            if (cls == 8) for (int k = 0; k < 6; k++) dst[k] = 8'hFF;
            len_ok  = len >= 6;
            match   = cls == 0;
            mc      = cls >= 7;
            addr_ok = promisc | match | (mcast_en & mc);
            cfail   = crc_rej & bit'(bad);
            keep    = len_ok & addr_ok & !cfail;
            exp     = {keep, !keep, cfail};
            if (!len_ok)                  tag = "R9";
            else if (cfail)               tag = "R7";
            else if (bad != 0)            tag = "R8";
            else if (promisc)             tag = "R5";
            else if (mc)                  tag = "R6";
            else if (match)               tag = "R4";
            else                          tag = "R3";
            send(len, bit'(bad), exp, tag);
          end

    // R10: promiscuous at SOF, cleared mid-frame, mismatching dst -> kept
    for (int k = 0; k < 6; k++) dst[k] = 8'h40 + 8'(k);
    {crc_rej, promisc, mcast_en} = 3'b010;
    mid_en = 1; alt_lo = addr_lo; alt_hi = addr_hi; alt_mode = 3'b000;
    send(8, 1'b0, 3'b100, "R10");
    // R10: matching address, address words changed mid-frame -> kept
    for (int k = 0; k < 6; k++) dst[k] = sta[k];
    alt_lo = 32'h0011_2233; alt_hi = 32'h0044_5566; alt_mode = 3'b000;
    send(7, 1'b0, 3'b100, "R10");
    // R10: rejection off at SOF, turned on mid-frame, bad CRC -> kept, no error
    set_station(8'h00, 8'h00);
    {crc_rej, promisc, mcast_en} = 3'b000;
    alt_lo = addr_lo; alt_hi = addr_hi; alt_mode = 3'b100;
    send(6, 1'b1, 3'b100, "R10");
    // R10: rejection on at SOF, cleared mid-frame, bad CRC -> dropped with error
    alt_mode = 3'b000;
    {crc_rej, promisc, mcast_en} = 3'b100;
    send(6, 1'b1, 3'b011, "R10");
    mid_en = 0;

    // back-to-back frames, verdict each time
    {crc_rej, promisc, mcast_en} = 3'b000;
    send(6, 1'b0, 3'b100, "R2");
    send(6, 1'b0, 3'b100, "R2");

    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule